// File: doc/BRIEF.md
# Functional-Unit Reservation Hazard Detector

This block decides, one candidate per clock, whether an instruction of a given class can start without colliding with earlier instructions over shared execution resources. Six resources are tracked: integer pipelines 0 and 1, the floating-point pipeline, result ports 0 and 1, and a divider that is not pipelined. Each class claims a fixed multi-cycle pattern of these resources. Where a pattern offers a choice between two resources, the lower-numbered one is taken when it is free.

A shift register of busy vectors, one row per future cycle, holds every claim already made. Row 0 is the current cycle. When a candidate fits, its pattern is merged into the rows, and the whole table moves forward by one row on each clock. The verdict, the integer pipeline and the result port chosen for the candidate are registered. A scheduler drives a class and a request strobe, and reads the verdict after the next edge.

Top module: `hzd_top`

## Requirements
- R1: Synchronous active-high reset clears every output to 0 and empties the table, so the first divide after reset is accepted.
- R2: A request presented in cycle t gives its verdict on the outputs after the clock edge that ends cycle t, and the verdict holds for one cycle. When req_valid_i is low, issue_ok_o, int_pipe_o and res_port_o are all 0 in the following cycle. They are also all 0 after a rejected request.
- R3: req_class_i encodes 0 = simple integer, 1 = multiply, 2 = divide, 3 = floating point. An accepted simple integer reports int_pipe_o = 0 because pipeline 0 is free in its issue cycle. An accepted multiply or divide reports int_pipe_o = 1. An accepted floating-point instruction reports int_pipe_o = 0.
- R4: The result port is claimed a fixed number of cycles after the issue cycle t. This is t+1 for simple integer, t+2 for floating point, t+3 for multiply and t+8 for divide.
- R5: res_port_o is 0 when port 0 is free in the claimed cycle, and 1 when port 0 is taken but port 1 is free.
- R6: A request is rejected when both result ports are already taken in its port cycle. Nothing granted ever double-books a resource in any cycle.
- R7: A divide holds the divider from t+1 through t+8. A later divide is rejected until 8 cycles after the previous accepted divide, and is accepted exactly then if its port is free.
- R8: Rejected requests and idle cycles reserve nothing.
- R9: A reservation keeps its absolute cycle as the table advances, and expires once that cycle has passed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid_i | input | 1 | Candidate present this cycle |
| req_class_i | input | 2 | Candidate class (see R3) |
| issue_ok_o | output | 1 | Registered: candidate was accepted |
| int_pipe_o | output | 1 | Registered: integer pipeline used (0 when not accepted) |
| res_port_o | output | 1 | Registered: result port chosen (0 when not accepted) |

## Verification
Every verdict appears one clock after its request. The bench therefore drives a request on a falling edge and compares the three outputs on the next falling edge. That comparison uses the value that a behavioural table model, updated at the same point, predicted for that request. Port and divider effects land 1 to 8 cycles after issue. The directed sequences place the follow-up requests on exactly those cycles, for example a simple instruction 7 cycles after a divide and a second divide 7 and then 8 cycles after the first. A long pseudo-random stream follows, checked against the model on every clock.

// File: rtl/hzd_pkg.sv
package hzd_pkg;
  localparam int NUM_UNITS = 6;
  // resource bit positions inside one table row
  localparam int U_I0 = 0;
  localparam int U_I1 = 1;
  localparam int U_FP = 2;
  localparam int U_P0 = 3;
  localparam int U_P1 = 4;
  localparam int U_DV = 5;

  typedef logic [NUM_UNITS-1:0] unit_vec_t;

  typedef enum logic [1:0] {
    CLS_INT = 2'd0,
    CLS_MUL = 2'd1,
    CLS_DIV = 2'd2,
    CLS_FLT = 2'd3
  } iclass_t;
endpackage

// File: rtl/hzd_pattern.sv
module hzd_pattern
  import hzd_pkg::*;
#(
  parameter int DEPTH         = 10,
  parameter int INT_PORT_SLOT = 1,
  parameter int FLT_PORT_SLOT = 2,
  parameter int MUL_PORT_SLOT = 3,
  parameter int DIV_SPAN      = 8
) (
  input  iclass_t                             cls_i,
  input  logic [DEPTH-1:0][NUM_UNITS-1:0]     tbl_i,
  output logic                                fits_o,
  output logic                                pipe_o,
  output logic                                port_o,
  output logic [DEPTH-1:0][NUM_UNITS-1:0]     pat_o
);
  localparam int SW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [SW-1:0]        ps;
  unit_vec_t            port_row;
  logic                 pipe_free;
  logic                 port_free;
  logic                 divider_free;

  // port cycle per class
  always_comb begin
    case (cls_i)
      CLS_INT: ps = SW'(INT_PORT_SLOT);
      CLS_MUL: ps = SW'(MUL_PORT_SLOT);
      CLS_DIV: ps = SW'(DIV_SPAN);
      default: ps = SW'(FLT_PORT_SLOT);
    endcase
  end

  assign port_row  = tbl_i[ps];
  assign port_o    = port_row[U_P0];
  assign port_free = !(port_row[U_P0] && port_row[U_P1]);

  // issue-cycle pipeline choice, ordered alternatives
  always_comb begin
    case (cls_i)
      CLS_INT: begin
        pipe_o    = tbl_i[0][U_I0];
        pipe_free = !(tbl_i[0][U_I0] && tbl_i[0][U_I1]);
      end
      CLS_MUL, CLS_DIV: begin
        pipe_o    = 1'b1;
        pipe_free = !tbl_i[0][U_I1];
      end
      default: begin
        pipe_o    = 1'b0;
        pipe_free = !tbl_i[0][U_FP];
      end
    endcase
  end

  // non-pipelined divider must be idle over the whole span
  always_comb begin
    divider_free = 1'b1;
    if (cls_i == CLS_DIV) begin
      for (int k = 1; k <= DIV_SPAN; k++) begin
        if (tbl_i[SW'(k)][U_DV]) divider_free = 1'b0;
      end
    end
  end

  assign fits_o = pipe_free && port_free && divider_free;

  // reservation pattern for the candidate
  always_comb begin
    pat_o = '0;
    case (cls_i)
      CLS_INT: begin
        if (pipe_o) pat_o[0][U_I1] = 1'b1;
        else        pat_o[0][U_I0] = 1'b1;
      end
      CLS_MUL, CLS_DIV: pat_o[0][U_I1] = 1'b1;
      default:          pat_o[0][U_FP] = 1'b1;
    endcase
    if (port_o) pat_o[ps][U_P1] = 1'b1;
    else        pat_o[ps][U_P0] = 1'b1;
    if (cls_i == CLS_DIV) begin
      for (int k = 1; k <= DIV_SPAN; k++) pat_o[SW'(k)][U_DV] = 1'b1;
    end
  end
endmodule

// File: rtl/hzd_table.sv
module hzd_table
  import hzd_pkg::*;
#(
  parameter int DEPTH = 10
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic                            commit_i,
  input  logic [DEPTH-1:0][NUM_UNITS-1:0] pat_i,
  output logic [DEPTH-1:0][NUM_UNITS-1:0] tbl_o
);
  logic [DEPTH-1:0][NUM_UNITS-1:0] tbl_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      tbl_q <= '0;
    end else begin
      for (int k = 0; k < DEPTH-1; k++) begin
        tbl_q[k] <= tbl_q[k+1] | (commit_i ? pat_i[k+1] : '0);
      end
      tbl_q[DEPTH-1] <= '0;
    end
  end

  assign tbl_o = tbl_q;

  for (genvar k = 0; k < DEPTH; k++) begin : g_chk
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
      commit_i |-> ((tbl_q[k] & pat_i[k]) == '0)); // R6
    if (k < DEPTH-1) begin : g_shift
      AST_KEEP_CYCLE: assert property (@(posedge clk) disable iff (rst)
        !rst |=> ((tbl_q[k] & $past(tbl_q[k+1])) == $past(tbl_q[k+1]))); // R9
    end
  end
endmodule

// File: rtl/hzd_top.sv
module hzd_top
  import hzd_pkg::*;
#(
  parameter int DEPTH         = 10,
  parameter int INT_PORT_SLOT = 1,
  parameter int FLT_PORT_SLOT = 2,
  parameter int MUL_PORT_SLOT = 3,
  parameter int DIV_SPAN      = 8
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       req_valid_i,
  input  logic [1:0] req_class_i,
  output logic       issue_ok_o,
  output logic       int_pipe_o,
  output logic       res_port_o
);
  logic [DEPTH-1:0][NUM_UNITS-1:0] tbl;
  logic [DEPTH-1:0][NUM_UNITS-1:0] pat;
  logic fits, pipe_sel, port_sel, commit;
  logic ok_q, pipe_q, port_q;

  hzd_pattern #(
    .DEPTH(DEPTH), .INT_PORT_SLOT(INT_PORT_SLOT), .FLT_PORT_SLOT(FLT_PORT_SLOT),
    .MUL_PORT_SLOT(MUL_PORT_SLOT), .DIV_SPAN(DIV_SPAN)
  ) u_pattern (
    .cls_i (iclass_t'(req_class_i)),
    .tbl_i (tbl),
    .fits_o(fits),
    .pipe_o(pipe_sel),
    .port_o(port_sel),
    .pat_o (pat)
  );

  assign commit = req_valid_i && fits;

  hzd_table #(.DEPTH(DEPTH)) u_table (
    .clk     (clk),
    .rst     (rst),
    .commit_i(commit),
    .pat_i   (pat),
    .tbl_o   (tbl)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ok_q   <= 1'b0;
      pipe_q <= 1'b0;
      port_q <= 1'b0;
    end else begin
      ok_q   <= commit;
      pipe_q <= commit && pipe_sel;
      port_q <= commit && port_sel;
    end
  end

  assign issue_ok_o = ok_q;
  assign int_pipe_o = pipe_q;
  assign res_port_o = port_q;

  AST_IDLE_NO_GRANT: assert property (@(posedge clk) disable iff (rst)
    !req_valid_i |=> !issue_ok_o); // R2
  AST_MULDIV_PIPE1: assert property (@(posedge clk) disable iff (rst)
    (req_valid_i && (req_class_i == 2'd1 || req_class_i == 2'd2)) |=> (!issue_ok_o || int_pipe_o)); // R3
endmodule

// File: tb/hzd_top_tb_top.sv
`timescale 1ns/1ps
module hzd_top_tb_top;
  localparam int DEPTH = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [1:0] req_class = 2'd0;
  logic issue_ok, int_pipe, res_port;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  bit [5:0] mt [DEPTH];

  always #2.5 clk = ~clk;

  hzd_top dut_i (
    .clk(clk), .rst(rst), .req_valid_i(req_valid), .req_class_i(req_class),
    .issue_ok_o(issue_ok), .int_pipe_o(int_pipe), .res_port_o(res_port)
  );

  task automatic check3(input bit g, input bit p, input bit t, input string tag);
    checks++;
    if (issue_ok !== g || int_pipe !== p || res_port !== t) begin
      fails++;
      $display("FAIL %s actual ok=%0b pipe=%0b port=%0b expected ok=%0b pipe=%0b port=%0b",
               tag, issue_ok, int_pipe, res_port, g, p, t);
    end
  endtask

  // drive at falling edge, model the verdict, compare one cycle later
  task automatic step(input bit v, input int c, input string tag);
    int ps, pu;
    bit ok, et;
    ps = (c == 0) ? 1 : (c == 1) ? 3 : (c == 2) ? 8 : 2;
    pu = 0; et = 0;
    ok = v;
    if (c == 0) begin
      if (!mt[0][0]) pu = 0; else if (!mt[0][1]) pu = 1; else ok = 0;
    end else if (c == 3) begin
      pu = 2; if (mt[0][2]) ok = 0;
    end else begin
      pu = 1; if (mt[0][1]) ok = 0;
    end
    if (!mt[ps][3]) et = 0; else if (!mt[ps][4]) et = 1; else ok = 0;
    if (c == 2) for (int k = 1; k <= 8; k++) if (mt[k][5]) ok = 0;
    if (ok) begin
      mt[0][pu] = 1'b1;
      mt[ps][3 + int'(et)] = 1'b1;
      if (c == 2) for (int k = 1; k <= 8; k++) mt[k][5] = 1'b1;
    end
    for (int k = 0; k < DEPTH-1; k++) mt[k] = mt[k+1];
    mt[DEPTH-1] = '0;
    req_valid = v;
    req_class = 2'(c);
    @(posedge clk);
    @(negedge clk);
    check3(ok, ok && (pu == 1), ok && et, tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, "R8 idle");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL R2 watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    bit [15:0] lfsr;
    for (int k = 0; k < DEPTH; k++) mt[k] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check3(0, 0, 0, "R1 reset");
    rst = 1'b0;
    @(negedge clk);
    check3(0, 0, 0, "R1 after reset");

    // first divide after reset is accepted
    step(1, 2, "R1 div after reset");   check3(1, 1, 0, "R1 div literal");
    idle(DEPTH);

    step(1, 0, "R3 simple");            check3(1, 0, 0, "R3 simple literal");
    step(0, 2, "R2 idle");              check3(0, 0, 0, "R2 idle literal");
    step(1, 3, "R3 float");             check3(1, 0, 0, "R3 float literal");
    idle(DEPTH);

    // port contention on one future cycle
    step(1, 1, "R4 mult");              check3(1, 1, 0, "R4 mult literal");
    step(1, 3, "R5 float");             check3(1, 0, 1, "R5 float port1");
    step(1, 0, "R6 simple");            check3(0, 0, 0, "R6 simple blocked");
    step(1, 0, "R8 simple");            check3(1, 0, 0, "R8 simple after reject");
    idle(DEPTH);

    // reservation tied to its own cycle
    step(1, 1, "R9 mult a");            check3(1, 1, 0, "R9 mult a literal");
    step(1, 1, "R9 mult b");            check3(1, 1, 0, "R9 mult b literal");
    idle(DEPTH);

    // divider spacing and divide result port
    step(1, 2, "R7 div");               check3(1, 1, 0, "R7 div literal");
    for (int i = 1; i <= 6; i++) begin
      step(1, 2, "R7 div busy");        check3(0, 0, 0, "R7 div busy literal");
    end
    step(1, 0, "R4 simple vs div port"); check3(1, 0, 1, "R4 simple port1");
    step(1, 2, "R7 div at +8");         check3(1, 1, 0, "R8 div at +8 literal");
    for (int i = 1; i <= 7; i++) begin
      step(1, 2, "R7 div busy2");       check3(0, 0, 0, "R7 div busy2 literal");
    end
    step(1, 2, "R7 div at +8 again");   check3(1, 1, 0, "R7 div again literal");
    idle(DEPTH);

    // pseudo-random stream against the model
    lfsr = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[5], int'(lfsr[3:2]), "R5 R6 R7 R9 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule